// File: doc/BRIEF.md
# Flash-Clearable 1K x 4 Static Memory

This block is a synchronous behavioural model of a 1024-word by 4-bit static memory. It has separate data-in and data-out ports, and the output port carries an enable qualifier that stands in for a three-state driver. Four active-low controls steer each clock edge: chip select, write enable, output enable and a clear command. Writes store a nibble at the addressed word. Reads are registered, so the word appears on the output one cycle after the address is sampled.

The clear command zeroes the whole array in a single clock. It does not rewrite every location. Instead it drops a per-word valid flag, and any word whose flag is low reads back as zero. The clear is accepted only when the chip is selected and write enable is high. While the clear line is low, the output is disabled and no write takes effect. A system reset puts the block in the same state as a completed clear.

Top module: `flashclr_ram`

## Requirements
- R1: While rst_n is low, and in the cycles that follow it, dout_en is 0 and dout is 0. Every word reads as 4'b0000 until it is written.
- R2: At a rising edge with cs_n=0, we_n=0 and clr_n=1, din is stored at word addr.
- R3: At a rising edge with cs_n=0, we_n=1, oe_n=0 and clr_n=1, the next cycle shows dout_en=1 and dout equal to the last value stored at addr since the most recent clear or reset. A word not stored since then reads 4'b0000.
- R4: After an edge with cs_n=1, oe_n=1 or we_n=0 (a write), dout_en is 0 in the following cycle.
- R5: At a rising edge with clr_n=0, cs_n=0 and we_n=1, the clear is accepted and every word reads 4'b0000 from the very next read onwards, one clock later.
- R6: A low clr_n at an edge where cs_n=1 leaves the array contents unchanged.
- R7: At an edge with clr_n low, no write takes effect, whatever cs_n and we_n are. dout_en is 0 in the following cycle. With we_n=0 the clear is also refused, so the contents are kept.
- R8: After a clear, a write to one word followed by reads of that word and of its neighbour returns the written value and 4'b0000 respectively.
- R9: dout is 4'b0000 in every cycle in which dout_en is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all controls are sampled on its rising edge |
| rst_n | input | 1 | Active-low system reset; invalidates every word |
| addr | input | 10 | Word address |
| din | input | 4 | Write data |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| clr_n | input | 1 | Active-low whole-array clear command |
| dout | output | 4 | Registered read data, zero while disabled |
| dout_en | output | 1 | High when dout is driven (models the three-state enable) |

## Verification
The assertions take for granted that the controls are settled at each rising edge and that rst_n is driven low for at least one edge before use. The data-path property for the clear also relies on the clear and the following read sitting on consecutive edges with no write in between. The bench changes every input only on the falling edge. Its random phase keeps addresses inside a small window so that reads land on written words, and it issues clears sparsely. This means the clear property's antecedent does occur, alongside long runs of ordinary traffic.

// File: rtl/flashclr_pkg.sv
package flashclr_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_READ,
    OP_WRITE,
    OP_CLEAR,
    OP_HOLD
  } fc_op_e;

  // Classify one set of sampled controls. The clear line dominates.
  function automatic fc_op_e fc_decode(input logic cs_n, input logic we_n,
                                       input logic oe_n, input logic clr_n);
    fc_op_e op;
    if (!clr_n) begin
      op = (!cs_n && we_n) ? OP_CLEAR : OP_HOLD;
    end else if (cs_n) begin
      op = OP_IDLE;
    end else if (!we_n) begin
      op = OP_WRITE;
    end else if (!oe_n) begin
      op = OP_READ;
    end else begin
      op = OP_IDLE;
    end
    return op;
  endfunction

endpackage

// File: rtl/fc_ctrl.sv
module fc_ctrl
  import flashclr_pkg::*;
(
  input  logic   cs_n,
  input  logic   we_n,
  input  logic   oe_n,
  input  logic   clr_n,
  output fc_op_e op,
  output logic   wr_fire,
  output logic   rd_fire,
  output logic   clr_fire
);

  always_comb begin
    op       = fc_decode(cs_n, we_n, oe_n, clr_n);
    wr_fire  = (op == OP_WRITE);
    rd_fire  = (op == OP_READ);
    clr_fire = (op == OP_CLEAR);
  end

endmodule

// File: rtl/fc_valid.sv
module fc_valid #(
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_fire,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_valid
);

  logic [DEPTH-1:0] flags;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (clr_fire) begin
      flags <= '0;
    end else if (wr_fire) begin
      flags[addr] <= 1'b1;
    end
  end

  assign rd_valid = flags[addr];

endmodule

// File: rtl/fc_store.sv
module fc_store #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_word
);

  // One single-bit array per data lane.
  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    logic cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_fire) begin
        cells[addr] <= din[g];
      end
    end

    assign rd_word[g] = cells[addr];
  end

endmodule

// File: rtl/fc_outreg.sv
module fc_outreg #(
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  // A word without its valid flag is presented as zero.
  function automatic logic [DATA_W-1:0] mask_word(input logic v,
                                                  input logic [DATA_W-1:0] w);
    return v ? w : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else if (rd_fire) begin
      dout    <= mask_word(rd_valid, rd_word);
      dout_en <= 1'b1;
    end else begin
      dout    <= '0;
      dout_en <= 1'b0;
    end
  end

endmodule

// File: rtl/flashclr_ram.sv
module flashclr_ram
  import flashclr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              clr_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  fc_op_e            op;
  logic              wr_fire;
  logic              rd_fire;
  logic              clr_fire;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_word;

  fc_ctrl u_ctrl (
    .cs_n     (cs_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .clr_n    (clr_n),
    .op       (op),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire),
    .clr_fire (clr_fire)
  );

  fc_valid #(.ADDR_W(ADDR_W)) u_valid (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_fire (clr_fire),
    .wr_fire  (wr_fire),
    .addr     (addr),
    .rd_valid (rd_valid)
  );

  fc_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .wr_fire (wr_fire),
    .addr    (addr),
    .din     (din),
    .rd_word (rd_word)
  );

  fc_outreg #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_fire  (rd_fire),
    .rd_valid (rd_valid),
    .rd_word  (rd_word),
    .dout     (dout),
    .dout_en  (dout_en)
  );

endmodule

// File: rtl/flashclr_ram_chk.sv
module flashclr_ram_chk #(
  parameter int DATA_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              clr_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              wr_fire,
  input logic              clr_fire
);

  // Set one edge after reset is released, so $past never reaches into reset.
  logic live;
  always_ff @(posedge clk) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  AST_DISABLED_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0)); // R9

  AST_DESELECT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || oe_n || !we_n) |=> !dout_en); // R4

  AST_CLEAR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> !dout_en); // R7

  AST_WRITE_NOT_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |-> clr_n); // R7

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we_n && !oe_n && clr_n) |=> dout_en); // R3

  AST_READ_AFTER_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(clr_fire) && !cs_n && we_n && !oe_n && clr_n) |=> (dout == '0)); // R5

endmodule

bind flashclr_ram flashclr_ram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .we_n     (we_n),
  .oe_n     (oe_n),
  .clr_n    (clr_n),
  .dout     (dout),
  .dout_en  (dout_en),
  .wr_fire  (wr_fire),
  .clr_fire (clr_fire)
);

// File: tb/tb_flashclr_ram.sv
`timescale 1ns/1ps
module tb_flashclr_ram;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] addr = '0;
  logic [3:0] din = '0;
  logic       cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, clr_n = 1'b1;
  logic [3:0] dout;
  logic       dout_en;

  always #2.5 clk = ~clk;

  flashclr_ram dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .clr_n(clr_n),
    .dout(dout), .dout_en(dout_en)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  logic [3:0] shadow [1024];

  // One cycle: drive on the falling edge, predict, compare just after the rising edge.
  task automatic cyc(input bit c, input bit w, input bit o, input bit r,
                     input int a, input logic [3:0] d, input string tag);
    bit         exp_en;
    logic [3:0] exp_d;
    @(negedge clk);
    cs_n = c; we_n = w; oe_n = o; clr_n = r; addr = a[9:0]; din = d;
    exp_en = 1'b0;
    exp_d  = 4'h0;
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) shadow[i] = 4'h0;
    end else if (!r) begin
      if (!c && w) for (int i = 0; i < 1024; i++) shadow[i] = 4'h0;
    end else if (!c && !w) begin
      shadow[a] = d;
    end else if (!c && !o) begin
      exp_en = 1'b1;
      exp_d  = shadow[a];
    end
    @(posedge clk);
    #1;
    vectors++;
    if (dout_en !== exp_en || dout !== exp_d) begin
      miscompares++;
      $display("FAIL %s: dout_en=%0b dout=%h, expected dout_en=%0b dout=%h (addr %0d)",
               tag, dout_en, dout, exp_en, exp_d, a);
    end
  endtask

  task automatic rd(input int a, input string tag);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, a, 4'h0, tag);
  endtask

  task automatic wr(input int a, input logic [3:0] d, input string tag);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, a, d, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, 1'b1, i, 4'h0, "R1");
    @(negedge clk) rst_n = 1'b1;
    rd(0, "R1"); rd(5, "R1"); rd(1023, "R1");

    // R2: writes (output stays disabled, R4)
    wr(5, 4'hA, "R2"); wr(6, 4'h3, "R2"); wr(1023, 4'hF, "R2"); wr(0, 4'h9, "R2");
    // R3: reads of stored and unstored words
    rd(5, "R3"); rd(6, "R3"); rd(1023, "R3"); rd(0, "R3"); rd(7, "R3");
    // R4: output gating
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 5, 4'h0, "R4");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 5, 4'h0, "R4");
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 5, 4'h1, "R4");
    rd(5, "R4");

    // R6: clear refused while deselected
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 5, 4'h0, "R6");
    rd(5, "R6"); rd(1023, "R6");
    // R7: clear low with write enable low: no clear, no write
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 5, 4'h7, "R7");
    rd(5, "R7"); rd(6, "R7");

    // R5: accepted clear, then immediate reads
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 5, 4'h0, "R5");
    rd(5, "R5"); rd(1023, "R5"); rd(0, "R5");

    // R8: write after clear, read it and its neighbour
    wr(100, 4'hC, "R8");
    rd(100, "R8"); rd(101, "R8");
    // R9 is covered by every disabled-cycle comparison above and below

    // Mixed traffic in a small address window
    for (int n = 0; n < 4000; n++) begin
      int k;
      k = $urandom_range(0, 99);
      cyc(k < 30 ? 1'b0 : bit'($urandom_range(0, 1)),
          bit'($urandom_range(0, 2) != 0),
          bit'($urandom_range(0, 3) == 0),
          (k == 7) ? 1'b0 : 1'b1,
          $urandom_range(0, 15), 4'($urandom_range(0, 15)), "R3");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule